// File: doc/BRIEF.md
# Degauss Cycle Sequencer

This block times a core-demagnetization cycle for a closed-loop current sensor. The degauss waveform generator runs only while the strobe `cyc_active` is high. The analog decaying waveform itself is produced outside this block. Here, only the timing and the control decisions are made.

A cycle can start in two ways:
- **Deliberate request.** The request pin, which is asynchronous, is first synchronized. It must then stay high for a long filter window before a cycle starts.
- **Power-up.** If the request is already high when power-good rises, a cycle starts after a shorter fixed power-up delay.

A filtered low level on the request aborts a running cycle. A short low glitch has no effect. Every cycle ends with a one-cycle done pulse and a status bit that tells an abort apart from a normal completion.

The output `not_valid` drives the active-low error flag. It is high during the power-up window and during every cycle.

Top module: `degauss_seq`

## Requirements
- R1: The request passes through a two-stage synchronizer, so a change on `req_async` reaches the filters two edges later. Rising edges are counted from the first edge at which `req_async` is sampled high, and that edge counts as edge 1. If the request is sampled high at START_CYC consecutive edges while the sequencer is armed, `cyc_active` goes high at edge START_CYC+2.
- R2: A high run of START_CYC-1 or fewer consecutive samples never starts a cycle.
- R3: A cycle that is not aborted keeps `cyc_active` high for exactly RUN_CYC clock cycles, then ends normally.
- R4: During a cycle, if the request is sampled low at ABORT_CYC consecutive edges, the cycle ends. Counting the first low sample as edge 1, `cyc_active` falls at edge ABORT_CYC+2. Low runs of ABORT_CYC-1 samples or fewer do not abort the cycle.
- R5: Edges are counted from the first rising edge after `pwr_good` rises, and that edge counts as edge 1. If the request is high from reset release onward, `cyc_active` rises at edge PWRUP_CYC, with no START_CYC filter. PWRUP_CYC must be at least 3.
- R6: If the request is low throughout the power-up window, no cycle runs.
- R7: `not_valid` is high while `pwr_good` is low, during the PWRUP_CYC power-up window, and while `cyc_active` is high. It is low at all other times.
- R8: After a cycle ends, a request that is still high does not start a new cycle. A new cycle needs the request to be sampled low, then held high for the full START_CYC samples again.
- R9: `done_pulse` is high for exactly one cycle. That cycle is the one that begins at the edge where `cyc_active` falls. `done_pulse` is low at all other times, and low in reset.
- R10: `aborted` is 0 out of reset. It takes the value 1 when a cycle ends through an abort and 0 when a cycle completes normally, at the same edge as `done_pulse`. It holds that value until the next cycle ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| pwr_good | input | 1 | Power-good; low acts as asynchronous reset |
| req_async | input | 1 | Asynchronous degauss request pin |
| cyc_active | output | 1 | High while a degauss cycle runs |
| not_valid | output | 1 | High while the sensor output is not valid |
| done_pulse | output | 1 | One-cycle pulse when a cycle ends |
| aborted | output | 1 | 1 if the last cycle was aborted, 0 if it completed |

## Verification
The expected timing of each result is as follows:
- `cyc_active` rises START_CYC+2 edges after the first high sample.
- It falls ABORT_CYC+2 edges after the first low sample of an abort.
- It rises at edge PWRUP_CYC after power-good when the request is already high at power-up.
- `done_pulse` and `aborted` change on the same edge that drops `cyc_active`.

The bench keeps to these latencies as follows. It advances an edge-accurate reference model just after each rising edge, using the request value sampled at that edge. It compares all four outputs at the following falling edge, so every expected value lines up with the register stages that produce it. Directed runs place request pulses exactly one sample short of each filter window and exactly at it. A constrained-random phase then mixes run lengths and power-good drops.

// File: rtl/degauss_pkg.sv
package degauss_pkg;
    typedef enum logic [1:0] {
        DG_BOOT    = 2'd0,
        DG_ARMED   = 2'd1,
        DG_WAITLOW = 2'd2,
        DG_RUN     = 2'd3
    } dg_state_e;
endpackage

// File: rtl/degauss_sync.sv
module degauss_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sr_q;
    logic [STAGES-1:0] sr_d;

    always_comb begin
        sr_d = {sr_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/degauss_hold_filt.sv
module degauss_hold_filt #(
    parameter int LEN   = 8,
    parameter bit LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic hit
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] run_q;
    logic [CW-1:0] run_d;
    logic          match;

    always_comb begin
        match = (din == LEVEL);
        if (!match)                 run_d = '0;
        else if (run_q == CW'(LEN)) run_d = run_q;
        else                        run_d = run_q + 1'b1;
        hit = match && (run_q == CW'(LEN - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    // R2
    hit_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (LEN > 1)) |-> ($past(din) == LEVEL));
endmodule

// File: rtl/degauss_seq.sv
module degauss_seq
    import degauss_pkg::*;
#(
    parameter int START_CYC = 1280,
    parameter int ABORT_CYC = 1250,
    parameter int PWRUP_CYC = 600,
    parameter int RUN_CYC   = 5_500_000,
    parameter int SYNC_STG  = 2
) (
    input  logic clk,
    input  logic pwr_good,
    input  logic req_async,
    output logic cyc_active,
    output logic not_valid,
    output logic done_pulse,
    output logic aborted
);
    localparam int MAXC = (RUN_CYC > PWRUP_CYC) ? RUN_CYC : PWRUP_CYC;
    localparam int TW   = $clog2(MAXC + 1);

    typedef struct packed {
        dg_state_e     st;
        logic [TW-1:0] cnt;
        logic          done;
        logic          abrt;
    } ctl_t;

    ctl_t ctl_q, ctl_d;
    logic req_s;
    logic start_hit, abort_hit;

    degauss_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(pwr_good), .din(req_async), .dout(req_s)
    );

    degauss_hold_filt #(.LEN(START_CYC), .LEVEL(1'b1)) u_start_filt (
        .clk(clk), .rst_n(pwr_good), .din(req_s), .hit(start_hit)
    );

    degauss_hold_filt #(.LEN(ABORT_CYC), .LEVEL(1'b0)) u_abort_filt (
        .clk(clk), .rst_n(pwr_good), .din(req_s), .hit(abort_hit)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.st)
            DG_BOOT: begin
                if (ctl_q.cnt == TW'(PWRUP_CYC - 1)) begin
                    ctl_d.cnt = '0;
                    ctl_d.st  = req_s ? DG_RUN : DG_ARMED;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            DG_ARMED: begin
                if (start_hit) begin
                    ctl_d.st  = DG_RUN;
                    ctl_d.cnt = '0;
                end
            end
            DG_WAITLOW: begin
                if (!req_s) ctl_d.st = DG_ARMED;
            end
            DG_RUN: begin
                if (abort_hit) begin
                    ctl_d.st   = DG_WAITLOW;
                    ctl_d.cnt  = '0;
                    ctl_d.done = 1'b1;
                    ctl_d.abrt = 1'b1;
                end else if (ctl_q.cnt == TW'(RUN_CYC - 1)) begin
                    ctl_d.st   = DG_WAITLOW;
                    ctl_d.cnt  = '0;
                    ctl_d.done = 1'b1;
                    ctl_d.abrt = 1'b0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            default: ctl_d.st = DG_BOOT;
        endcase
    end

    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            ctl_q.st   <= DG_BOOT;
            ctl_q.cnt  <= '0;
            ctl_q.done <= 1'b0;
            ctl_q.abrt <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cyc_active = (ctl_q.st == DG_RUN);
    assign not_valid  = (ctl_q.st == DG_RUN) || (ctl_q.st == DG_BOOT);
    assign done_pulse = ctl_q.done;
    assign aborted    = ctl_q.abrt;

    // R3
    run_len_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        cyc_active |-> (ctl_q.cnt < TW'(RUN_CYC)));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        done_pulse |=> !done_pulse);

    // R9
    done_at_fall_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        $fell(cyc_active) |-> done_pulse);

    // R8
    no_retrig_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        (ctl_q.st == DG_WAITLOW) |=> !cyc_active);

    // R4
    abort_cause_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        (cyc_active && abort_hit) |=> (done_pulse && aborted && !cyc_active));

    // R10
    status_hold_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        !done_pulse |-> $stable(aborted));
endmodule

// File: tb/degauss_seq_tb.sv
module degauss_seq_tb;
    localparam int START = 8;
    localparam int ABRT  = 6;
    localparam int PWR   = 5;
    localparam int RUNC  = 60;

    logic clk = 1'b0;
    logic pwr_good = 1'b0;
    logic req = 1'b0;
    logic cyc_active, not_valid, done_pulse, aborted;

    always #4 clk = ~clk;

    degauss_seq #(
        .START_CYC(START), .ABORT_CYC(ABRT), .PWRUP_CYC(PWR), .RUN_CYC(RUNC)
    ) u_dut (
        .clk(clk), .pwr_good(pwr_good), .req_async(req),
        .cyc_active(cyc_active), .not_valid(not_valid),
        .done_pulse(done_pulse), .aborted(aborted)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    string tag = "R7";

    // reference model: 0 boot, 1 armed, 2 wait-low, 3 running
    int m_st, m_cnt, m_hi, m_lo;
    bit m_r1, m_r2, m_done, m_ab;

    function automatic bit exp_cyc();
        return m_st == 3;
    endfunction

    function automatic bit exp_nv();
        return (m_st == 3) || (m_st == 0);
    endfunction

    task automatic model_reset();
        m_st = 0; m_cnt = 0; m_hi = 0; m_lo = 0;
        m_r1 = 0; m_r2 = 0; m_done = 0; m_ab = 0;
    endtask

    task automatic model_step(input bit smp);
        bit s, sh, ah;
        s  = m_r2;
        m_r2 = m_r1;
        m_r1 = smp;
        sh = s && (m_hi == START - 1);
        ah = !s && (m_lo == ABRT - 1);
        m_hi = s  ? ((m_hi < START) ? m_hi + 1 : m_hi) : 0;
        m_lo = !s ? ((m_lo < ABRT) ? m_lo + 1 : m_lo) : 0;
        m_done = 0;
        case (m_st)
            0: if (m_cnt == PWR - 1) begin m_cnt = 0; m_st = s ? 3 : 1; end
               else m_cnt++;
            1: if (sh) begin m_st = 3; m_cnt = 0; end
            2: if (!s) m_st = 1;
            default: begin
                if (ah) begin m_st = 2; m_cnt = 0; m_done = 1; m_ab = 1; end
                else if (m_cnt == RUNC - 1) begin m_st = 2; m_cnt = 0; m_done = 1; m_ab = 0; end
                else m_cnt++;
            end
        endcase
    endtask

    task automatic check(input string t, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", t, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check(tag,   cyc_active, exp_cyc());
        check("R7",  not_valid,  exp_nv());
        check("R9",  done_pulse, m_done);
        check("R10", aborted,    m_ab);
    endtask

    // one cycle: compare at negedge, drive, then advance model at posedge
    task automatic tick(input bit r, input bit pg);
        @(negedge clk);
        compare_all();
        req = r;
        pwr_good = pg;
        if (!pg) model_reset();
        @(posedge clk);
        #1;
        if (pg) model_step(r);
    endtask

    task automatic hold(input int n, input bit r, input string t);
        tag = t;
        for (int i = 0; i < n; i++) tick(r, 1'b1);
    endtask

    task automatic power_cycle(input bit r, input string t);
        tag = t;
        for (int i = 0; i < 3; i++) tick(r, 1'b0);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        model_reset();
        // R7 reset state, R5 power-up start with request high
        power_cycle(1'b1, "R7");
        hold(PWR + 2, 1'b1, "R5");
        hold(RUNC + 4, 1'b1, "R3");
        // R8 request still high after completion: no new cycle
        hold(30, 1'b1, "R8");
        hold(4, 1'b0, "R8");
        // R2 pulse one sample short
        hold(START - 1, 1'b1, "R2");
        hold(6, 1'b0, "R2");
        // R1 exact filter length start
        hold(START, 1'b1, "R1");
        hold(12, 1'b1, "R1");
        // R4 short low glitch ignored, then a real abort
        hold(ABRT - 1, 1'b0, "R4");
        hold(4, 1'b1, "R4");
        hold(ABRT + 4, 1'b0, "R4");
        // R6 request low through power-up
        power_cycle(1'b0, "R6");
        hold(PWR + 20, 1'b0, "R6");
        // constrained random mix
        for (int k = 0; k < 4000; k++) begin
            int len;
            bit lvl;
            lvl = $urandom_range(0, 1);
            if ($urandom_range(0, 9) == 0) len = $urandom_range(RUNC, RUNC + 20);
            else len = $urandom_range(1, 2 * START);
            if ($urandom_range(0, 59) == 0) power_cycle(lvl, "R5");
            hold(len, lvl, "R1");
        end
        @(negedge clk);
        compare_all();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule